// File: doc/BRIEF.md
# Supply Controller Register Slave on a Two-Wire Serial Bus

This block lets a host processor drive the control settings of a satellite antenna supply controller over a two-wire serial bus that follows the I2C protocol. Behind the bus it holds one 8-bit system register. A write sets six control fields: pulsed current limiting, tone path enable, continuous tone, line-drop compensation, high-voltage select and output enable. These fields leave the block as plain level outputs. A read returns the three output-voltage fields, two live fault flags (over-temperature and overload) and three constant zero bits.

The slave answers to a 7-bit device address. The upper six bits are fixed by a parameter, and the lowest bit follows the `addr_sel_i` level. SCL and SDA are sampled into the system clock domain through a synchroniser, and edge detection follows it. The slave drives SDA only by pulling it low, through `sda_oe_o`. While the undervoltage-lockout input is high, the register is forced to zero and the slave stays silent on the bus.

Controller states are `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_WRITE`, `ST_WRITE_ACK`, `ST_READ`, `ST_READ_ACK` and `ST_SKIP`. A START moves any state to `ST_ADDR`. A STOP moves any state to `ST_IDLE`. Lockout forces `ST_IDLE` and blocks every other transition. The remaining transitions happen on the falling SCL edge that follows each complete group of eight bits:
- `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches and to `ST_SKIP` when it does not.
- `ST_ADDR_ACK` goes to `ST_READ` or `ST_WRITE`, as the R/W bit says.
- `ST_WRITE` goes to `ST_WRITE_ACK`, and `ST_WRITE_ACK` goes back to `ST_WRITE`.
- `ST_READ` goes to `ST_READ_ACK`.
- `ST_READ_ACK` goes to `ST_READ` when the master acknowledged and to `ST_SKIP` when it did not.

Top module: `supply_ctl_i2c`

## Requirements
- R1: The slave acknowledges an address byte equal to {6'b000101, addr_sel_i, rw} by pulling SDA low during the ninth clock. rw is 0 for write and 1 for read.
- R2: An address byte that does not match gets no acknowledge, and the data that follows leaves the control outputs unchanged.
- R3: A write data byte maps bit 7 to pulse_lim, bit 6 to tone_path, bit 5 to tone_cont, bit 4 to boost, bit 3 to hi_volt and bit 2 to enable. Bits 1:0 are not stored. The outputs change only while SCL is low, after the eighth data bit.
- R4: A read byte is {3'b000, boost, hi_volt, enable, over-temperature flag, overload flag}, sent MSB first.
- R5: The fault flags in a read byte are the values captured when the address byte, or the previous master acknowledge, was taken. Flag changes after that point do not alter the byte in flight.
- R6: After a read byte, a master ACK makes the slave send another byte. A master NACK ends the read, and SDA stays released until the next START.
- R7: While lockout_i is high, all control outputs are zero and no transfer is acknowledged.
- R8: After reset, all control outputs are zero and SDA is released.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: A repeated START in the middle of a transaction restarts address decoding.
- R11: Every data byte of a multi-byte write is acknowledged, and the last byte determines the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockout_i | input | 1 | Supply undervoltage lockout, active high |
| addr_sel_i | input | 1 | Level for the lowest device address bit |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| over_temp_i | input | 1 | Live over-temperature flag |
| overload_i | input | 1 | Live overload flag |
| pulse_lim_o | output | 1 | Pulsed current limiting select |
| tone_path_o | output | 1 | Tone output path enable |
| tone_cont_o | output | 1 | Continuous tone enable |
| boost_o | output | 1 | Line-drop compensation |
| hi_volt_o | output | 1 | High output voltage select |
| enable_o | output | 1 | Power stage enable |

## Verification
Writes use the all-ones byte, two alternating patterns and a byte with only the test bits set. These show whether each field lands in its own position and whether the test bits are dropped. Reads are taken with different fault flag combinations, and the flags are flipped between the address acknowledge and the data byte. This separates a captured snapshot from a live path, and the second byte after a master ACK shows that the capture is refreshed. Wrong-select addresses, a repeated START and transfers under lockout test the decode and silence paths. A bus monitor watches whether SDA drive ever changes while SCL is high.

// File: rtl/supply_ctl_pkg.sv
package supply_ctl_pkg;

    localparam int ADDR_HI_W = 6;
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_SKIP
    } bus_state_e;

    typedef struct packed {
        logic pulse_lim;
        logic tone_path;
        logic tone_cont;
        logic boost;
        logic hi_volt;
        logic enable;
    } ctl_fields_t;

    localparam int CTL_W = $bits(ctl_fields_t);

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_prev;
    logic          sda_prev;

    // Bus idles high, so every stage resets to one.
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
                    sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    assign sda_o      = sda_pipe[LAST];
    assign scl_rise_o = scl_pipe[LAST] & ~scl_prev;
    assign scl_fall_o = ~scl_pipe[LAST] & scl_prev;
    assign start_o    = scl_pipe[LAST] & scl_prev & sda_prev & ~sda_pipe[LAST];
    assign stop_o     = scl_pipe[LAST] & scl_prev & ~sda_prev & sda_pipe[LAST];

endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import supply_ctl_pkg::*;
#(
    parameter logic [ADDR_HI_W-1:0] DEV_ADDR_HI = 6'b000101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout_i,
    input  logic              addr_sel_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [CTL_W-1:0]  wr_ctl_o
);

    bus_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              byte_full_q;
    logic [BYTE_W-1:0] rx_sr_q;
    logic [BYTE_W-1:0] tx_sr_q;
    logic              mst_ack_q;

    logic addr_hit;
    logic counting;
    logic byte_end;

    assign addr_hit = (rx_sr_q[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel_i});
    assign counting = (state_q == ST_ADDR) || (state_q == ST_WRITE) || (state_q == ST_READ);
    assign byte_end = scl_fall_i && byte_full_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (lockout_i) begin
            state_d = ST_IDLE;
        end else if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall_i) state_d = rx_sr_q[0] ? ST_READ : ST_WRITE;
                ST_WRITE:     if (byte_end) state_d = ST_WRITE_ACK;
                ST_WRITE_ACK: if (scl_fall_i) state_d = ST_WRITE;
                ST_READ:      if (byte_end) state_d = ST_READ_ACK;
                ST_READ_ACK:  if (scl_fall_i) state_d = mst_ack_q ? ST_READ : ST_SKIP;
                ST_SKIP:      state_d = ST_SKIP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bit counter and receive shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            byte_full_q <= 1'b0;
            rx_sr_q     <= '0;
        end else if (lockout_i || start_i || !counting) begin
            bit_cnt_q   <= '0;
            byte_full_q <= 1'b0;
        end else if (scl_rise_i) begin
            bit_cnt_q   <= bit_cnt_q + 1'b1;
            byte_full_q <= (bit_cnt_q == CNT_W'(BYTE_W - 1));
            if (state_q != ST_READ) rx_sr_q <= {rx_sr_q[BYTE_W-2:0], sda_s_i};
        end
    end

    // Transmit shifter: snapshot at address acknowledge and at master ACK
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr_q   <= '0;
            mst_ack_q <= 1'b0;
        end else begin
            if (state_q == ST_ADDR && byte_end && addr_hit) begin
                tx_sr_q <= rd_byte_i;
            end else if (state_q == ST_READ_ACK && scl_rise_i) begin
                mst_ack_q <= ~sda_s_i;
                if (!sda_s_i) tx_sr_q <= rd_byte_i;
            end else if (state_q == ST_READ && scl_fall_i) begin
                tx_sr_q <= {tx_sr_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_WRITE_ACK: sda_oe_o = 1'b1;
            ST_READ:                   sda_oe_o = ~tx_sr_q[BYTE_W-1];
            default:                   sda_oe_o = 1'b0;
        endcase
    end

    assign wr_en_o  = (state_q == ST_WRITE) && byte_end && !lockout_i && !start_i && !stop_i;
    assign wr_ctl_o = rx_sr_q[BYTE_W-1 -: CTL_W];

endmodule

// File: rtl/ctl_register.sv
module ctl_register
    import supply_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout_i,
    input  logic              wr_en_i,
    input  logic [CTL_W-1:0]  wr_ctl_i,
    input  logic              over_temp_i,
    input  logic              overload_i,
    output ctl_fields_t       fields_o,
    output logic [BYTE_W-1:0] rd_byte_o
);

    ctl_fields_t fields_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         fields_q <= '0;
        else if (lockout_i) fields_q <= '0;
        else if (wr_en_i)   fields_q <= ctl_fields_t'(wr_ctl_i);
    end

    assign fields_o  = fields_q;
    assign rd_byte_o = {3'b000, fields_q.boost, fields_q.hi_volt, fields_q.enable,
                        over_temp_i, overload_i};

endmodule

// File: rtl/supply_ctl_i2c.sv
module supply_ctl_i2c
    import supply_ctl_pkg::*;
#(
    parameter int                   SYNC_STAGES = 2,
    parameter logic [ADDR_HI_W-1:0] DEV_ADDR_HI = 6'b000101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lockout_i,
    input  logic addr_sel_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe_o,
    input  logic over_temp_i,
    input  logic overload_i,
    output logic pulse_lim_o,
    output logic tone_path_o,
    output logic tone_cont_o,
    output logic boost_o,
    output logic hi_volt_o,
    output logic enable_o
);

    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic              wr_en;
    logic [CTL_W-1:0]  wr_ctl;
    logic [BYTE_W-1:0] rd_byte;
    ctl_fields_t       fields;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    i2c_byte_fsm #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .lockout_i  (lockout_i),
        .addr_sel_i (addr_sel_i),
        .sda_s_i    (sda_s),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .rd_byte_i  (rd_byte),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_ctl_o   (wr_ctl)
    );

    ctl_register u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .lockout_i   (lockout_i),
        .wr_en_i     (wr_en),
        .wr_ctl_i    (wr_ctl),
        .over_temp_i (over_temp_i),
        .overload_i  (overload_i),
        .fields_o    (fields),
        .rd_byte_o   (rd_byte)
    );

    assign pulse_lim_o = fields.pulse_lim;
    assign tone_path_o = fields.tone_path;
    assign tone_cont_o = fields.tone_cont;
    assign boost_o     = fields.boost;
    assign hi_volt_o   = fields.hi_volt;
    assign enable_o    = fields.enable;

endmodule

// File: rtl/supply_ctl_i2c_chk.sv
module supply_ctl_i2c_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lockout_i,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic [5:0] ctl
);

    // R7
    lockout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_i |=> (ctl == 6'b0));

    // R7
    lockout_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout_i && $past(lockout_i)) |-> !sda_oe_o);

    // R9
    drive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R9
    drive_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe_o) && !lockout_i && !$past(lockout_i)) |-> !scl_i);

    // R3
    ctl_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lockout_i && !$past(lockout_i) && !$stable(ctl)) |-> !scl_i);

    // R8
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (ctl == 6'b0));

endmodule

bind supply_ctl_i2c supply_ctl_i2c_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lockout_i (lockout_i),
    .scl_i     (scl_i),
    .sda_oe_o  (sda_oe_o),
    .ctl       ({pulse_lim_o, tone_path_o, tone_cont_o, boost_o, hi_volt_o, enable_o})
);

// File: tb/test_supply_ctl_i2c.sv
`timescale 1ns/1ps
module test_supply_ctl_i2c;

    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lockout = 1'b0;
    logic addr_sel = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic ot = 1'b0;
    logic ovl = 1'b0;
    logic sda_oe;
    logic pl, tp, tc, bo, hv, en;
    wire  sda_bus = sda_m & ~sda_oe;
    wire  [5:0] ctl = {pl, tp, tc, bo, hv, en};

    int checks = 0;
    int fails = 0;
    int r9_viol = 0;

    always #2.5 clk = ~clk;

    supply_ctl_i2c i_supply_ctl_i2c (
        .clk(clk), .rst_n(rst_n), .lockout_i(lockout), .addr_sel_i(addr_sel),
        .scl_i(scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .over_temp_i(ot), .overload_i(ovl),
        .pulse_lim_o(pl), .tone_path_o(tp), .tone_cont_o(tc),
        .boost_o(bo), .hi_volt_o(hv), .enable_o(en)
    );

    // R9 monitor: drive may change only while SCL is low
    logic scl_d = 1'b1, oe_d = 1'b0, lk_d = 1'b0;
    always @(negedge clk) begin
        if (rst_n && scl && scl_d && !lockout && !lk_d && (sda_oe != oe_d)) r9_viol++;
        scl_d = scl; oe_d = sda_oe; lk_d = lockout;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl = 1'b1;   wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b0;   wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b1;   wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(Q);
    endtask

    task automatic clk_bit(input logic drv, output logic seen);
        sda_m = drv; wait_cyc(Q);
        scl = 1'b1;  wait_cyc(Q);
        seen = sda_bus; wait_cyc(Q);
        scl = 1'b0;  wait_cyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    function automatic logic [7:0] addr_byte(input logic sel, input logic rd);
        return {6'b000101, sel, rd};
    endfunction

    task automatic do_write(input logic [7:0] d, input string req);
        logic a;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b0), a);
        chk({req, " addr ack"}, {7'b0, a}, 8'h01);
        send_byte(d, a);
        chk({req, " data ack"}, {7'b0, a}, 8'h01);
        bus_stop();
        chk({req, " outputs"}, {2'b0, ctl}, {2'b0, d[7:2]});
    endtask

    task automatic t_reset();
        chk("R8 ctl after reset", {2'b0, ctl}, 8'h00);
        chk("R8 sda released", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic t_write_patterns();
        do_write(8'hFC, "R1 R3 all ones");
        do_write(8'hA8, "R3 pattern A8");
        do_write(8'h57, "R3 pattern 57");
        do_write(8'h03, "R3 test bits only");
    endtask

    task automatic t_wrong_addr();
        logic a;
        do_write(8'h54, "R2 setup");
        bus_start();
        send_byte(addr_byte(1'b1, 1'b0), a);
        chk("R2 wrong select no ack", {7'b0, a}, 8'h00);
        send_byte(8'hFC, a);
        chk("R2 data after miss no ack", {7'b0, a}, 8'h00);
        bus_stop();
        chk("R2 outputs unchanged", {2'b0, ctl}, 8'h15);
        bus_start();
        send_byte(8'h34, a);
        chk("R2 foreign address no ack", {7'b0, a}, 8'h00);
        bus_stop();
    endtask

    task automatic t_read_layout();
        logic a;
        logic [7:0] b;
        do_write(8'h14, "R4 setup");
        ot = 1'b1; ovl = 1'b0;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b1), a);
        chk("R1 read addr ack", {7'b0, a}, 8'h01);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R4 read byte ot", b, 8'b000_101_10);
        ot = 1'b0; ovl = 1'b1;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b1), a);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R4 read byte ovl", b, 8'b000_101_01);
    endtask

    task automatic t_snapshot_continue();
        logic a;
        logic [7:0] b1, b2;
        do_write(8'h0C, "R5 setup");
        ot = 1'b0; ovl = 1'b1;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b1), a);
        ot = 1'b1; ovl = 1'b0;
        recv_byte(1'b1, b1);
        recv_byte(1'b0, b2);
        chk("R6 released after nack", {7'b0, sda_oe}, 8'h00);
        bus_stop();
        chk("R5 first byte holds snapshot", b1, 8'b000_011_01);
        chk("R6 second byte after master ack", b2, 8'b000_011_10);
    endtask

    task automatic t_multi_write();
        logic a;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b0), a);
        send_byte(8'h04, a);
        chk("R11 first data ack", {7'b0, a}, 8'h01);
        send_byte(8'h80, a);
        chk("R11 second data ack", {7'b0, a}, 8'h01);
        bus_stop();
        chk("R11 last byte wins", {2'b0, ctl}, 8'h20);
    endtask

    task automatic t_repeated_start();
        logic a;
        logic [7:0] b;
        ot = 1'b0; ovl = 1'b0;
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b0), a);
        send_byte(8'h1C, a);
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b1), a);
        chk("R10 ack after repeated start", {7'b0, a}, 8'h01);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R10 read after repeated start", b, 8'b000_111_00);
    endtask

    task automatic t_lockout();
        logic a;
        do_write(8'hFC, "R7 setup");
        lockout = 1'b1;
        wait_cyc(4);
        chk("R7 cleared under lockout", {2'b0, ctl}, 8'h00);
        bus_start();
        send_byte(addr_byte(addr_sel, 1'b0), a);
        chk("R7 no ack under lockout", {7'b0, a}, 8'h00);
        send_byte(8'hFC, a);
        bus_stop();
        chk("R7 no write under lockout", {2'b0, ctl}, 8'h00);
        lockout = 1'b0;
        wait_cyc(4);
        do_write(8'h24, "R7 after lockout");
    endtask

    task automatic t_select_high();
        addr_sel = 1'b1;
        do_write(8'hC8, "R1 select high");
        addr_sel = 1'b0;
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_write_patterns();
        t_wrong_addr();
        t_read_layout();
        t_snapshot_continue();
        t_multi_write();
        t_repeated_start();
        t_lockout();
        t_select_high();
        chk("R9 drive changes with SCL high", r9_viol[7:0], 8'h00);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule